// File: doc/BRIEF.md
# Wide-to-narrow register bus bridge

This block sits between a processor-side register port with a wide data word and a narrow control/status register bus. Each processor access becomes a burst of narrow accesses, one chunk per cycle. A write word is cut into chunks. Read chunks are gathered back into one wide word. The processor side uses a level request that it holds until a one-cycle acknowledge arrives.

The narrow accesses go out in ascending address order, and every access uses the full chunk count, even when the target register is narrower than the wide word. This keeps the downstream register logic atomic: it snapshots a register on the first chunk and commits it on the last. Narrow read data returns one cycle after its strobe, and reads are pipelined so that a new chunk strobe goes out every cycle. Locations that hold no register bits read as zero, so the unused upper part of a gathered word is zero.

The chunk ratio must be a power of two, and this is checked at elaboration. The address of chunk i is the processor word address times the ratio, plus i.

Top module: `csr_width_bridge`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both narrow strobes and `cpu_ack` are low. A reset in the middle of an access stops the burst at once.
- R2: Every accepted access gives exactly RATIO = CPU_DW/CSR_DW narrow strobes of one kind, in consecutive cycles, starting the cycle after acceptance.
- R3: Chunk i of an access to processor word W is presented at narrow address W*RATIO + i, for i = 0 to RATIO-1, in ascending order.
- R4: The write strobe for chunk i carries bits [i*CSR_DW +: CSR_DW] of the accepted write word.
- R5: Narrow read data present in the cycle after the read strobe of chunk i lands in bits [i*CSR_DW +: CSR_DW] of `cpu_rdata`. The bus value in any other cycle is not used.
- R6: All RATIO chunks are issued even for a register narrower than CPU_DW. Padding chunks that read as zero give zero upper bits in `cpu_rdata`.
- R7: A write is acknowledged by a `cpu_ack` pulse exactly one cycle long, one cycle after its last write strobe. This is RATIO+1 cycles after the acceptance edge.
- R8: A read is acknowledged by a one-cycle `cpu_ack`, one cycle after the last chunk's data cycle (RATIO+2 cycles after acceptance). `cpu_rdata` holds the gathered word during that cycle.
- R9: A request is taken only when the bridge is idle. Changes to `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` during a burst or its acknowledge cycle have no effect, and no strobe appears outside a burst.
- R10: The read strobe and the write strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_wdata | input | CPU_DW | Write word |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | CPU_DW | Gathered read word, valid with `cpu_ack` on reads |
| csr_addr | output | CPU_AW+log2(RATIO) | Narrow bus chunk address |
| csr_rd_stb | output | 1 | Narrow read strobe |
| csr_rdata | input | CSR_DW | Narrow read data, valid the cycle after the strobe |
| csr_wdata | output | CSR_DW | Narrow write chunk |
| csr_wr_stb | output | 1 | Narrow write strobe |

## Verification
On every cycle, the assertions check several things: the strobes never overlap, chunk addresses step by one within a burst, the chunk index advances once per cycle, the acknowledge is a single pulse that follows the last write strobe or the last read capture, and a busy bridge holds its latched address and direction. Each read capture is also checked against the bus value of the previous cycle. Only the bench scenarios can show data placement against an independent model of the narrow registers with padding. The same holds for the exact acknowledge latency counted from the request, for ignoring scrambled inputs in the middle of a burst, and for a clean stop when reset arrives during an access.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DRAIN = 2'd2,
    SQ_ACK   = 2'd3
  } seq_state_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int idx_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

endpackage

// File: rtl/csr_bridge_seq.sv
module csr_bridge_seq #(
  parameter int RATIO  = 4,
  parameter int CPU_AW = 6,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [CPU_AW-1:0] addr,
  input  logic              rd_done,
  output logic              accept,
  output logic              issue,
  output logic              op_we,
  output logic [CPU_AW-1:0] word_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              first,
  output logic              last,
  output logic              ack
);
  import csr_bridge_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

  seq_state_e state;

  assign accept = (state == SQ_IDLE) && req;
  assign issue  = (state == SQ_ISSUE);
  assign first  = issue && (idx_q == '0);
  assign last   = issue && (idx_q == LAST_IDX);
  assign ack    = (state == SQ_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      idx_q  <= '0;
      op_we  <= 1'b0;
      word_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (req) begin
            op_we  <= we;
            word_q <= addr;
            idx_q  <= '0;
            state  <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (idx_q == LAST_IDX) begin
            idx_q <= '0;
            state <= op_we ? SQ_ACK : SQ_DRAIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SQ_DRAIN: begin
          if (rd_done) state <= SQ_ACK;
        end
        SQ_ACK:  state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) ack |=> !ack); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue && !last) |=> (issue && idx_q == IDX_W'($past(idx_q) + 1'b1))); // R2
  AST_WR_ACK: assert property (@(posedge clk) disable iff (rst)
    (last && op_we) |=> ack); // R7
  AST_RD_ACK: assert property (@(posedge clk) disable iff (rst) rd_done |=> ack); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE) |=> ($stable(word_q) && $stable(op_we))); // R9

endmodule

// File: rtl/csr_bridge_wsplit.sv
module csr_bridge_wsplit #(
  parameter int RATIO  = 4,
  parameter int CSR_DW = 8,
  parameter int IDX_W  = 2,
  localparam int CPU_DW = RATIO * CSR_DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CPU_DW-1:0] wdata_in,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  output logic [CSR_DW-1:0] chunk_out
);
  logic [CPU_DW-1:0] held;
  logic [CSR_DW-1:0] parts [RATIO];

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= wdata_in;
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_part
    assign parts[g] = held[g*CSR_DW +: CSR_DW];
  end

  assign chunk_out = en ? parts[idx] : '0;

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    en |=> (load || $stable(held))); // R4

endmodule

// File: rtl/csr_bridge_rgather.sv
module csr_bridge_rgather #(
  parameter int RATIO  = 4,
  parameter int CSR_DW = 8,
  parameter int IDX_W  = 2,
  localparam int CPU_DW = RATIO * CSR_DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CSR_DW-1:0] csr_rdata,
  output logic              rd_done,
  output logic [CPU_DW-1:0] word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RATIO - 1);

  logic              cap_v;
  logic [IDX_W-1:0]  cap_idx;
  logic [CSR_DW-1:0] parts [RATIO];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_v   <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_v   <= rd_issue;
      cap_idx <= idx;
    end
  end

  assign rd_done = cap_v && (cap_idx == LAST_IDX);

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear)                          parts[g] <= '0;
      else if (cap_v && cap_idx == IDX_W'(g))    parts[g] <= csr_rdata;
    end
    assign word[g*CSR_DW +: CSR_DW] = parts[g];
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cap_v |=> (parts[$past(cap_idx)] == $past(csr_rdata))); // R5

endmodule

// File: rtl/csr_width_bridge.sv
module csr_width_bridge #(
  parameter int CPU_DW = 32,
  parameter int CSR_DW = 8,
  parameter int CPU_AW = 6,
  localparam int RATIO  = CPU_DW / CSR_DW,
  localparam int LOG_R  = $clog2(RATIO),
  localparam int CSR_AW = CPU_AW + LOG_R
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [CPU_DW-1:0] cpu_rdata,
  output logic [CSR_AW-1:0] csr_addr,
  output logic              csr_rd_stb,
  input  logic [CSR_DW-1:0] csr_rdata,
  output logic [CSR_DW-1:0] csr_wdata,
  output logic              csr_wr_stb
);
  localparam int IDX_W = csr_bridge_pkg::idx_bits(RATIO);

  if (!csr_bridge_pkg::is_pow2(RATIO) || (CPU_DW % CSR_DW) != 0) begin : g_bad_ratio
    $error("csr_width_bridge: CPU_DW/CSR_DW must be a whole power of two");
  end

  function automatic logic [CSR_AW-1:0] chunk_addr(input logic [CPU_AW-1:0] w,
                                                   input logic [IDX_W-1:0]  i);
    return CSR_AW'(w) * CSR_AW'(RATIO) + CSR_AW'(i);
  endfunction

  logic              accept, issue, op_we, first, last, rd_done;
  logic [CPU_AW-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;

  csr_bridge_seq #(.RATIO(RATIO), .CPU_AW(CPU_AW), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst(rst), .req(cpu_req), .we(cpu_we), .addr(cpu_addr),
    .rd_done(rd_done), .accept(accept), .issue(issue), .op_we(op_we),
    .word_q(word_q), .idx_q(idx_q), .first(first), .last(last), .ack(cpu_ack)
  );

  logic wr_issue, rd_issue;
  assign wr_issue = issue && op_we;
  assign rd_issue = issue && !op_we;

  csr_bridge_wsplit #(.RATIO(RATIO), .CSR_DW(CSR_DW), .IDX_W(IDX_W)) wsplit_i (
    .clk(clk), .rst(rst), .load(accept && cpu_we), .wdata_in(cpu_wdata),
    .en(wr_issue), .idx(idx_q), .chunk_out(csr_wdata)
  );

  csr_bridge_rgather #(.RATIO(RATIO), .CSR_DW(CSR_DW), .IDX_W(IDX_W)) rgather_i (
    .clk(clk), .rst(rst), .clear(accept), .rd_issue(rd_issue), .idx(idx_q),
    .csr_rdata(csr_rdata), .rd_done(rd_done), .word(cpu_rdata)
  );

  assign csr_addr   = issue ? chunk_addr(word_q, idx_q) : '0;
  assign csr_rd_stb = rd_issue;
  assign csr_wr_stb = wr_issue;

  AST_NO_DUAL_STB: assert property (@(posedge clk) disable iff (rst)
    !(csr_rd_stb && csr_wr_stb)); // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((csr_rd_stb || csr_wr_stb) && !first) |-> (csr_addr == CSR_AW'($past(csr_addr) + 1'b1))); // R3
  AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    first |-> (csr_addr == CSR_AW'(CSR_AW'(word_q) << LOG_R))); // R3
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> !(csr_rd_stb || csr_wr_stb)); // R9

endmodule

// File: tb/csr_width_bridge_tb_top.sv
`timescale 1ns/1ps
module csr_width_bridge_tb_top;
  localparam int CPU_DW = 32;
  localparam int CSR_DW = 8;
  localparam int CPU_AW = 6;
  localparam int RATIO  = CPU_DW / CSR_DW;
  localparam int CSR_AW = CPU_AW + $clog2(RATIO);
  localparam int NLOC   = 1 << CSR_AW;

  logic              clk = 1'b0;
  logic              rst;
  logic              cpu_req, cpu_we, cpu_ack;
  logic [CPU_AW-1:0] cpu_addr;
  logic [CPU_DW-1:0] cpu_wdata, cpu_rdata;
  logic [CSR_AW-1:0] csr_addr;
  logic              csr_rd_stb, csr_wr_stb;
  logic [CSR_DW-1:0] csr_rdata, csr_wdata;

  always #2 clk = ~clk;

  csr_width_bridge #(.CPU_DW(CPU_DW), .CSR_DW(CSR_DW), .CPU_AW(CPU_AW)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .csr_addr(csr_addr), .csr_rd_stb(csr_rd_stb), .csr_rdata(csr_rdata),
    .csr_wdata(csr_wdata), .csr_wr_stb(csr_wr_stb)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [CSR_DW-1:0] mem [NLOC];
  int          stb_cnt;
  bit          in_access;
  logic [CPU_AW-1:0] cur_word;
  logic [CPU_DW-1:0] cur_wdata;
  bit          cur_we;
  bit          rd_pend;
  logic [CSR_DW-1:0] rd_val;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Register model: word w holds (w % RATIO)+1 live chunks, the rest is padding.
  function automatic bit chunk_used(input int a);
    int w;
    int j;
    w = a / RATIO;
    j = a % RATIO;
    return j <= (w % RATIO);
  endfunction

  function automatic logic [CPU_DW-1:0] expect_word(input int w);
    logic [CPU_DW-1:0] e;
    e = '0;
    for (int j = 0; j < RATIO; j++)
      if (chunk_used(w * RATIO + j)) e[j*CSR_DW +: CSR_DW] = mem[w * RATIO + j];
    return e;
  endfunction

  function automatic logic [CSR_DW-1:0] slice_of(input logic [CPU_DW-1:0] d, input int i);
    return CSR_DW'(d >> (i * CSR_DW));
  endfunction

  // Narrow bus responder and strobe monitor, acting between clock edges.
  initial begin
    rd_pend = 0;
    csr_rdata = '0;
    forever begin
      @(negedge clk);
      csr_rdata = rd_pend ? rd_val : CSR_DW'($urandom);
      rd_pend = csr_rd_stb;
      if (csr_rd_stb) rd_val = chunk_used(int'(csr_addr)) ? mem[csr_addr] : '0;
      if (csr_rd_stb && csr_wr_stb) chk(0, "R10 dual strobe", 1, 0);
      if (csr_rd_stb || csr_wr_stb) begin
        if (!in_access) chk(0, "R9 strobe outside burst", 1, 0);
        else begin
          chk(int'(csr_addr) == int'(cur_word) * RATIO + stb_cnt, "R3 chunk address",
              longint'(csr_addr), longint'(int'(cur_word) * RATIO + stb_cnt));
          chk(csr_wr_stb == cur_we, "R2 strobe kind", csr_wr_stb, cur_we);
          if (csr_wr_stb)
            chk(csr_wdata == slice_of(cur_wdata, stb_cnt), "R4 write chunk",
                csr_wdata, slice_of(cur_wdata, stb_cnt));
        end
        stb_cnt++;
      end
      if (csr_wr_stb && chunk_used(int'(csr_addr))) mem[csr_addr] = csr_wdata;
    end
  end

  task automatic access(input bit we, input logic [CPU_AW-1:0] a,
                        input logic [CPU_DW-1:0] wd, input bit scramble);
    logic [CPU_DW-1:0] exp;
    int cyc;
    bit got;
    bit pad;
    exp = expect_word(int'(a));
    pad = (int'(a) % RATIO) != RATIO - 1;
    @(negedge clk);
    cur_word = a; cur_wdata = wd; cur_we = we; stb_cnt = 0; in_access = 1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; got = 0;
    while (!got && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (scramble) begin // R9: inputs change mid-burst
        cpu_addr = CPU_AW'($urandom); cpu_wdata = $urandom; cpu_we = $urandom;
      end
      if (cpu_ack) got = 1;
    end
    cpu_req = 0;
    in_access = 0;
    if (we) chk(cyc == RATIO + 1, "R7 write ack latency", cyc, RATIO + 1);
    else    chk(cyc == RATIO + 2, "R8 read ack latency", cyc, RATIO + 2);
    chk(stb_cnt == RATIO, pad ? "R6 padded strobe count" : "R2 strobe count", stb_cnt, RATIO);
    if (!we) chk(cpu_rdata == exp, pad ? "R6 padded read word" : "R5 read word", cpu_rdata, exp);
    @(negedge clk);
    chk(!cpu_ack && !csr_rd_stb && !csr_wr_stb, "R7 ack single pulse",
        {cpu_ack, csr_rd_stb, csr_wr_stb}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NLOC; i++) mem[i] = '0;
    in_access = 0; stb_cnt = 0; cur_we = 0; cur_word = '0; cur_wdata = '0;
    rst = 1; cpu_req = 1; cpu_we = 1; cpu_addr = '1; cpu_wdata = '1;
    repeat (3) begin
      @(negedge clk);
      chk(!csr_rd_stb && !csr_wr_stb && !cpu_ack, "R1 quiet in reset",
          {csr_rd_stb, csr_wr_stb, cpu_ack}, 0);
    end
    rst = 0; cpu_req = 0;
    @(negedge clk);
    chk(!csr_rd_stb && !csr_wr_stb && !cpu_ack, "R1 quiet after reset",
        {csr_rd_stb, csr_wr_stb, cpu_ack}, 0);

    // Directed: 24-bit register, full register, 8-bit register, top word.
    access(1, 6'd2, 32'hAABBCCDD, 0);
    access(0, 6'd2, '0, 0);
    access(1, 6'd3, 32'h12345678, 0);
    access(0, 6'd3, '0, 1);
    access(1, 6'd0, 32'hFFFFFF5A, 1);
    access(0, 6'd0, '0, 0);
    access(1, 6'd63, 32'hDEADBEEF, 0);
    access(0, 6'd63, '0, 0);

    // Reset in the middle of a read burst.
    @(negedge clk);
    cur_word = 6'd5; cur_we = 0; stb_cnt = 0; in_access = 1;
    cpu_req = 1; cpu_we = 0; cpu_addr = 6'd5;
    repeat (2) @(negedge clk);
    rst = 1; cpu_req = 0;
    @(negedge clk);
    in_access = 0;
    chk(!csr_rd_stb && !csr_wr_stb && !cpu_ack, "R1 reset stops burst",
        {csr_rd_stb, csr_wr_stb, cpu_ack}, 0);
    rst = 0;
    @(negedge clk);
    chk(!csr_rd_stb && !csr_wr_stb && !cpu_ack, "R1 idle after mid reset",
        {csr_rd_stb, csr_wr_stb, cpu_ack}, 0);

    for (int n = 0; n < 200; n++)
      access($urandom_range(0, 1), CPU_AW'($urandom), $urandom, $urandom_range(0, 1));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule